// File: doc/BRIEF.md
# Trailing and Leading Zero Counter

This block counts either the zeros below the lowest set bit (trailing zeros) or the zeros above the highest set bit (leading zeros) of a parameterized data word. A single mode input picks which count is produced. There are no registers in the block: the result follows the input within the same cycle. It is intended for normalisation shifters, unsigned divide-by-power-of-two shift amounts and priority-style bit scanning inside larger datapaths.

The input first passes through an orientation stage. In leading-zero mode this stage mirrors the word end to end, and in trailing-zero mode it passes the word unchanged. The lowest set bit of the oriented word is then isolated as `x & -x`, which gives a word with at most one bit set. An encoder turns that word into a bit position. For every bit, a precomputed position constant is masked by that bit, and all the masked constants are ORed together. An all-zero input has no defined count. In that case a separate flag goes high and the count reads zero.

Top module: `zero_count_unit`

## Requirements
- R1: With `mode_i` = 0 (trailing mode), `count_o` equals the bit position of the lowest set bit of `data_i`. Bit 0 is the least significant bit.
- R2: With `mode_i` = 1 (leading mode), `count_o` equals WIDTH-1 minus the bit position of the highest set bit of `data_i`.
- R3: For an input with exactly one bit set at position k, trailing mode gives k and leading mode gives WIDTH-1-k.
- R4: `count_o` is WIDTH bits wide. Bits at positions clog2(WIDTH) and above are always zero, and the value is always below WIDTH.
- R5: `undef_o` is 1 exactly when `data_i` is all zeros, in either mode.
- R6: While `undef_o` is 1, `count_o` is all zeros.
- R7: Set bits other than the one selected by the mode have no effect on the count. For example, an all-ones word gives 0 in both modes.
- R8: The block is combinational. A change on `data_i` or `mode_i` shows on the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_i | input | WIDTH | Word to scan |
| mode_i | input | 1 | 0 = trailing-zero count, 1 = leading-zero count |
| count_o | output | WIDTH | Zero count, zero-extended to the input width |
| undef_o | output | 1 | High when the input word is all zeros |

## Verification
Instances with widths of 8, 16 and 32 are compared against a behavioural scanning loop.

- **Single-bit words:** every position is tried in both modes. This separates a correct position encoder from one with a wrong or swapped constant. It also shows whether the mirroring in leading mode is right.
- **All-ones words:** these show that only the lowest bit of the oriented word reaches the encoder. An encoder fed unisolated bits would OR several positions together.
- **All-zero words:** these test the undefined flag and the forced-zero count.
- **Random words:** these catch orientation mistakes that appear only when both ends of the word hold set bits.
- **Mode changes with no clock edge:** these confirm the path has no storage.

// File: rtl/zero_count_pkg.sv
package zero_count_pkg;

  typedef enum logic {
    SCAN_TRAILING = 1'b0,
    SCAN_LEADING  = 1'b1
  } scan_mode_e;

  // Number of bits needed to hold a position inside a word of width w.
  function automatic int unsigned pos_width(input int unsigned w);
    return (w > 1) ? $clog2(w) : 1;
  endfunction

endpackage

// File: rtl/zc_orient.sv
// Passes the word through unchanged, or mirrors it end to end for leading scans.
module zc_orient
  import zero_count_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  input  scan_mode_e       mode_i,
  output logic [WIDTH-1:0] word_o
);

  logic [WIDTH-1:0] mirrored;

  for (genvar b = 0; b < WIDTH; b++) begin : g_mirror
    assign mirrored[b] = word_i[WIDTH-1-b];
  end

  always_comb begin
    word_o = (mode_i == SCAN_LEADING) ? mirrored : word_i;
  end

endmodule

// File: rtl/zc_isolate.sv
// Keeps only the lowest set bit: x & (-x).
module zc_isolate #(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] lowest_o
);

  logic [WIDTH-1:0] negated;

  always_comb begin
    negated  = ~word_i + WIDTH'(1);
    lowest_o = word_i & negated;
  end

endmodule

// File: rtl/zc_or_reduce.sv
// ORs a set of equal-width words into one.
module zc_or_reduce #(
  parameter int unsigned COUNT = 32,
  parameter int unsigned W     = 5
) (
  input  logic [COUNT-1:0][W-1:0] words_i,
  output logic [W-1:0]            merged_o
);

  always_comb begin
    merged_o = '0;
    for (int unsigned n = 0; n < COUNT; n++) begin
      merged_o = merged_o | words_i[n];
    end
  end

endmodule

// File: rtl/zc_onehot_index.sv
// Encodes a word with at most one set bit into that bit's position.
// Each bit gates its own position constant, and the gated terms are ORed.
module zc_onehot_index #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned POSW  = 5
) (
  input  logic [WIDTH-1:0] onehot_i,
  output logic [POSW-1:0]  index_o
);

  logic [WIDTH-1:0][POSW-1:0] gated;

  for (genvar g = 0; g < WIDTH; g++) begin : g_term
    localparam logic [POSW-1:0] POS_CONST = POSW'(g);
    assign gated[g] = {POSW{onehot_i[g]}} & POS_CONST;
  end

  zc_or_reduce #(
    .COUNT (WIDTH),
    .W     (POSW)
  ) u_merge (
    .words_i  (gated),
    .merged_o (index_o)
  );

endmodule

// File: rtl/zero_count_unit.sv
module zero_count_unit
  import zero_count_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic             mode_i,
  output logic [WIDTH-1:0] count_o,
  output logic             undef_o
);

  localparam int unsigned POSW = pos_width(WIDTH);

  scan_mode_e       scan_mode;
  logic [WIDTH-1:0] oriented;
  logic [WIDTH-1:0] lowest;
  logic [POSW-1:0]  position;

  assign scan_mode = scan_mode_e'(mode_i);

  zc_orient #(.WIDTH(WIDTH)) u_orient (
    .word_i (data_i),
    .mode_i (scan_mode),
    .word_o (oriented)
  );

  zc_isolate #(.WIDTH(WIDTH)) u_isolate (
    .word_i   (oriented),
    .lowest_o (lowest)
  );

  zc_onehot_index #(.WIDTH(WIDTH), .POSW(POSW)) u_index (
    .onehot_i (lowest),
    .index_o  (position)
  );

  if (WIDTH > POSW) begin : g_pad
    assign count_o = {{(WIDTH-POSW){1'b0}}, position};
  end else begin : g_nopad
    assign count_o = position[WIDTH-1:0];
  end

  assign undef_o = ~|data_i;

endmodule

// File: rtl/zero_count_checker.sv
module zero_count_checker #(
  parameter int unsigned WIDTH = 32
) (
  input logic [WIDTH-1:0] data_i,
  input logic             mode_i,
  input logic [WIDTH-1:0] count_o,
  input logic             undef_o
);

  localparam int unsigned POSW = (WIDTH > 1) ? $clog2(WIDTH) : 1;

  logic [WIDTH-1:0] hit_low, below_low;
  logic [WIDTH-1:0] hit_high, above_high;

  always_comb begin
    hit_low    = WIDTH'(1) << count_o[POSW-1:0];
    below_low  = hit_low - WIDTH'(1);
    hit_high   = WIDTH'(1) << (WIDTH - 1 - int'(count_o[POSW-1:0]));
    above_high = ~(hit_high | (hit_high - WIDTH'(1)));

    // R6: an undefined result reads as zero
    p_undef_count_zero_r6: assert (!undef_o || count_o == '0);
    // R4: upper count bits stay clear and the value stays in range
    p_count_range_r4: assert (count_o[WIDTH-1:POSW] == '0 && count_o < WIDTH);
    // R1: trailing mode points at the lowest set bit
    p_trailing_pos_r1: assert (undef_o || mode_i ||
                               ((data_i & hit_low) != '0 && (data_i & below_low) == '0));
    // R2: leading mode points at the highest set bit
    p_leading_pos_r2: assert (undef_o || !mode_i ||
                              ((data_i & hit_high) != '0 && (data_i & above_high) == '0));
    // R5: a nonzero word is never flagged undefined
    p_nonzero_defined_r5: assert (data_i == '0 || !undef_o);
  end

endmodule

bind zero_count_unit zero_count_checker #(.WIDTH(WIDTH)) u_zero_count_checker (
  .data_i  (data_i),
  .mode_i  (mode_i),
  .count_o (count_o),
  .undef_o (undef_o)
);

// File: tb/zero_count_unit_bench.sv
module zero_count_unit_bench;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  logic [31:0] stim = '0;
  logic        mode = 1'b0;

  logic [7:0]  c8;  logic u8;
  logic [15:0] c16; logic u16;
  logic [31:0] c32; logic u32;

  zero_count_unit #(.WIDTH(8))  u_zero_count_unit_w8 (
    .data_i(stim[7:0]),  .mode_i(mode), .count_o(c8),  .undef_o(u8));
  zero_count_unit #(.WIDTH(16)) u_zero_count_unit_w16 (
    .data_i(stim[15:0]), .mode_i(mode), .count_o(c16), .undef_o(u16));
  zero_count_unit #(.WIDTH(32)) u_zero_count_unit (
    .data_i(stim),       .mode_i(mode), .count_o(c32), .undef_o(u32));

  function automatic void ref_scan(input logic [31:0] w, input int width, input logic m,
                                   output int cnt, output logic undef);
    cnt = 0; undef = 1'b1;
    if (!m) begin
      for (int i = 0; i < width; i++) begin
        if (w[i]) begin cnt = i; undef = 1'b0; break; end
      end
    end else begin
      for (int i = width - 1; i >= 0; i--) begin
        if (w[i]) begin cnt = width - 1 - i; undef = 1'b0; break; end
      end
    end
    if (undef) cnt = 0;
  endfunction

  task automatic check_one(input string req, input int width,
                           input logic [31:0] got_c, input logic got_u);
    int exp_c; logic exp_u; logic [31:0] mask;
    mask = (width == 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 1);
    ref_scan(stim & mask, width, mode, exp_c, exp_u);
    checks++;
    if (got_c != 32'(exp_c) || got_u != exp_u) begin
      fails++;
      $display("FAIL %s w=%0d in=%h mode=%0b: got count=%0d undef=%0b, expected count=%0d undef=%0b",
               req, width, stim & mask, mode, got_c, got_u, exp_c, exp_u);
    end
  endtask

  task automatic check_all(input string req);
    check_one(req, 8,  {24'd0, c8},  u8);
    check_one(req, 16, {16'd0, c16}, u16);
    check_one(req, 32, c32,          u32);
  endtask

  task automatic apply(input logic [31:0] w, input logic m, input string req);
    @(posedge clk);
    stim = w; mode = m;
    @(negedge clk);
    check_all(req);
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    check_all("R5 R6 initial");
  endtask

  task automatic t_single_bits;
    for (int k = 0; k < 32; k++) begin
      apply(32'd1 << k, 1'b0, "R3 R1 single");
      apply(32'd1 << k, 1'b1, "R3 R2 single");
    end
  endtask

  task automatic t_all_ones;
    apply(32'hFFFF_FFFF, 1'b0, "R7 ones trailing");
    apply(32'hFFFF_FFFF, 1'b1, "R7 ones leading");
    apply(32'h8000_0001, 1'b0, "R7 ends trailing");
    apply(32'h8000_0001, 1'b1, "R7 ends leading");
  endtask

  task automatic t_all_zero;
    apply(32'd0, 1'b0, "R5 R6 zero trailing");
    apply(32'd0, 1'b1, "R5 R6 zero leading");
  endtask

  task automatic t_random;
    logic [31:0] w;
    for (int n = 0; n < 200; n++) begin
      w = $urandom();
      if (n % 4 == 1) w = w >> (n % 29);
      if (n % 4 == 2) w = w << (n % 29);
      apply(w, n[0], n[0] ? "R2 random" : "R1 random");
      checks++;
      if (c32[31:5] != '0 || c16[15:4] != '0 || c8[7:3] != '0) begin
        fails++;
        $display("FAIL R4 upper bits: got c8=%h c16=%h c32=%h, expected zero above position field",
                 c8, c16, c32);
      end
    end
  endtask

  task automatic t_no_clock;
    @(negedge clk);
    stim = 32'h0000_0F00; mode = 1'b0;
    #1; check_all("R8 comb trailing");
    mode = 1'b1;
    #1; check_all("R8 comb leading");
    stim = 32'h0000_0000;
    #1; check_all("R8 comb zero");
  endtask

  initial begin
    fork
      begin
        t_reset_state();
        t_single_bits();
        t_all_ones();
        t_all_zero();
        t_random();
        t_no_clock();
      end
      begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: got timeout, expected completion");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule